// File: doc/BRIEF.md
# Auto-Increment Indexed Memory Port

This block lets a host reach the words of an internal memory indirectly, through pairs of registers on a 32-bit register bus. Each pair is made of an index register, which holds a word pointer and two stepping switches, and a data register, which reads or writes the word that the pointer selects. Stepping is switched separately for data writes and for data reads, so a host can stream a buffer into memory or out of it without rewriting the pointer between words.

Several pairs sit side by side. Each has its own pointer, and all of them reach the same memory. Pair p places its index register at byte offset 8·p and its data register at 8·p+4. The memory behind the pairs is a synchronous single-port SRAM model with one cycle of read latency.

A two-state controller sequences the bus. `ST_IDLE` takes each request. Index accesses, data writes and unmapped accesses complete in that same cycle. A data read takes the `ST_IDLE -> ST_RD_WAIT` transition, which issues the SRAM read. `ST_RD_WAIT` returns the word and takes the unconditional `ST_RD_WAIT -> ST_IDLE` transition.

Top module: `indexed_mem_port`

## Requirements
- R1: After reset every index register reads 0: pointer 0 with both stepping switches off.
- R2: A write to an index register loads the word pointer from bits 15:2, the write-step switch from bit 24 and the read-step switch from bit 25, all in one access. A read of the index returns those fields in the same positions, with every other bit 0.
- R3: A data write stores the bus word in the memory word that the pointer selects. Only the low MEM_AW bits of the pointer select the word.
- R4: After a data write the pointer advances by one word if the write-step switch is set, and stays where it is if the switch is clear.
- R5: A data read returns the word at the pointer as it stood before the access. The pointer then advances by one word if the read-step switch is set, and stays where it is if the switch is clear.
- R6: A data read raises bus_ready in the cycle after the request is taken. Every other access raises bus_ready in the cycle it is taken.
- R7: Stepping from pointer 0x3FFF wraps to pointer 0.
- R8: Pair p has its index at byte offset 8·p and its data at 8·p+4. Accesses through one pair leave the pointer and switches of every other pair unchanged.
- R9: An access to an offset at or above 8·NUM_PORTS completes in one cycle and reads 0. It writes neither the memory nor any index: after it, the index registers read back unchanged and the memory words read back their earlier values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, held until bus_ready |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | BUS_AW | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ready is high |
| bus_ready | output | 1 | Access completes in this cycle |

## Verification
A pointer that is wrong inside the block shows at the ports within one access. The next index read returns the wrong field values. The next data read returns a word from the wrong place, and that word is visible once the read completes, one cycle after the request. A controller stuck in the wait state or leaving it early shows as a bus_ready that comes a cycle late or a cycle early. A stray step, or a step that was missed, shows as a shifted word in a streamed read and in the index read that follows it. Each of these is checked against a behavioural model on every access.

// File: rtl/mport_pkg.sv
package mport_pkg;
    localparam int WORD_AW  = 14;
    localparam int WSTEP_BIT = 24;
    localparam int RSTEP_BIT = 25;

    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_RD_WAIT = 1'b1
    } port_state_e;

    function automatic logic [31:0] pack_index(logic [WORD_AW-1:0] ptr,
                                               logic wstep, logic rstep);
        logic [31:0] v;
        v = '0;
        v[WORD_AW+1:2] = ptr;
        v[WSTEP_BIT]   = wstep;
        v[RSTEP_BIT]   = rstep;
        return v;
    endfunction
endpackage

// File: rtl/mport_index.sv
module mport_index
    import mport_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [31:0]        wdata,
    input  logic               bump,
    output logic [WORD_AW-1:0] ptr,
    output logic               wstep,
    output logic               rstep
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr   <= '0;
            wstep <= 1'b0;
            rstep <= 1'b0;
        end else if (load) begin
            ptr   <= wdata[WORD_AW+1:2];
            wstep <= wdata[WSTEP_BIT];
            rstep <= wdata[RSTEP_BIT];
        end else if (bump) begin
            ptr   <= ptr + 1'b1;
        end
    end

    // R2: an index load takes all three fields in one access
    a_r2_load_fields: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ptr == $past(wdata[WORD_AW+1:2])) && (wstep == $past(wdata[WSTEP_BIT]))
                 && (rstep == $past(wdata[RSTEP_BIT])));

    // R7: a step adds one word modulo the pointer range
    a_r7_step_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (bump && !load) |=> ptr == WORD_AW'($past(ptr) + 1'b1));

    // R4: with no load and no step the index holds
    a_r4_index_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!bump && !load) |=> $stable(ptr) && $stable(wstep) && $stable(rstep));
endmodule

// File: rtl/mport_sram.sv
module mport_sram #(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[addr] <= wdata;
            else    rdata     <= mem[addr];
        end
    end
endmodule

// File: rtl/indexed_mem_port.sv
module indexed_mem_port
    import mport_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int MEM_AW    = 8,
    parameter int BUS_AW    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_ready
);
    localparam int SEL_W = BUS_AW - 3;

    port_state_e state, state_nx;

    logic [SEL_W-1:0]   sel;
    logic               is_data;
    logic [NUM_PORTS-1:0] port_hit, idx_load, bump;
    logic [WORD_AW-1:0] ptr   [NUM_PORTS];
    logic [NUM_PORTS-1:0] wstep, rstep;
    logic               any_hit, accept, dread_go, dwrite_go;
    logic [WORD_AW-1:0] cur_ptr;
    logic               cur_wstep, cur_rstep;
    logic [31:0]        sram_q;

    assign sel     = bus_addr[BUS_AW-1:3];
    assign is_data = bus_addr[2];
    assign accept  = (state == ST_IDLE) && bus_req;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pair
        assign port_hit[p] = (sel == SEL_W'(p));
        assign idx_load[p] = accept && port_hit[p] && !is_data && bus_we;
        assign bump[p]     = port_hit[p] && ((dwrite_go && wstep[p]) || (dread_go && rstep[p]));

        mport_index u_index (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (idx_load[p]),
            .wdata (bus_wdata),
            .bump  (bump[p]),
            .ptr   (ptr[p]),
            .wstep (wstep[p]),
            .rstep (rstep[p])
        );
    end

    always_comb begin
        cur_ptr   = '0;
        cur_wstep = 1'b0;
        cur_rstep = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (port_hit[p]) begin
                cur_ptr   = ptr[p];
                cur_wstep = wstep[p];
                cur_rstep = rstep[p];
            end
        end
    end

    assign any_hit   = |port_hit;
    assign dread_go  = accept && any_hit && is_data && !bus_we;
    assign dwrite_go = accept && any_hit && is_data && bus_we;

    mport_sram #(.AW(MEM_AW), .DW(32)) u_sram (
        .clk   (clk),
        .en    (dread_go || dwrite_go),
        .we    (dwrite_go),
        .addr  (cur_ptr[MEM_AW-1:0]),
        .wdata (bus_wdata),
        .rdata (sram_q)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (dread_go) state_nx = ST_RD_WAIT;
            ST_RD_WAIT: state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        bus_ready = 1'b0;
        bus_rdata = '0;
        unique case (state)
            ST_IDLE: begin
                bus_ready = bus_req && !dread_go;
                if (bus_req && any_hit && !is_data && !bus_we)
                    bus_rdata = pack_index(cur_ptr, cur_wstep, cur_rstep);
            end
            ST_RD_WAIT: begin
                bus_ready = 1'b1;
                bus_rdata = sram_q;
            end
            default: ;
        endcase
    end

    // R6: a data read completes exactly one cycle after it is taken
    a_r6_read_ready_next: assert property (@(posedge clk) disable iff (!rst_n)
        dread_go |=> bus_ready && (state == ST_RD_WAIT));

    // R6: the wait state lasts a single cycle
    a_r6_wait_one: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_WAIT) |=> (state == ST_IDLE));

    // R8: at most one pair decodes any offset
    a_r8_one_pair: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_hit));

    initial begin
        a_r3_mem_fits: assert (MEM_AW <= WORD_AW && NUM_PORTS >= 1 && NUM_PORTS <= 8);
    end
endmodule

// File: tb/test_indexed_mem_port.sv
module test_indexed_mem_port;
    localparam int NP  = 4;
    localparam int MAW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;

    int checks = 0;
    int errors = 0;

    logic [13:0] m_ptr [NP];
    bit          m_ws  [NP];
    bit          m_rs  [NP];
    logic [31:0] m_mem [int];

    indexed_mem_port #(.NUM_PORTS(NP), .MEM_AW(MAW), .BUS_AW(8)) i_indexed_mem_port (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [7:0] a, input logic [31:0] d,
                          output logic [31:0] q, output int lat);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        lat = 1;
        #2;
        while (!bus_ready && lat < 10) begin
            @(negedge clk);
            lat++;
            #2;
        end
        q = bus_rdata;
        @(posedge clk);
        #1;
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    function automatic logic [31:0] m_index(int p);
        return {6'b0, m_rs[p], m_ws[p], 8'b0, m_ptr[p], 2'b00};
    endfunction

    task automatic idx_write(input int p, input logic [31:0] v, input string tag);
        logic [31:0] q; int lat;
        access(1'b1, 8'(p * 8), v, q, lat);
        m_ptr[p] = v[15:2]; m_ws[p] = v[24]; m_rs[p] = v[25];
        check({tag, " index write latency"}, 32'(lat), 32'd1);
    endtask

    task automatic idx_read(input int p, input string tag);
        logic [31:0] q; int lat;
        access(1'b0, 8'(p * 8), 32'h0, q, lat);
        check({tag, " index readback"}, q, m_index(p));
        check({tag, " index read latency"}, 32'(lat), 32'd1);
    endtask

    task automatic dat_write(input int p, input logic [31:0] v, input string tag);
        logic [31:0] q; int lat;
        access(1'b1, 8'(p * 8 + 4), v, q, lat);
        m_mem[int'(m_ptr[p]) % (1 << MAW)] = v;
        if (m_ws[p]) m_ptr[p] = m_ptr[p] + 14'd1;
        check({tag, " data write latency"}, 32'(lat), 32'd1);
    endtask

    task automatic dat_read(input int p, input string tag);
        logic [31:0] q; int lat;
        access(1'b0, 8'(p * 8 + 4), 32'h0, q, lat);
        check({tag, " data read word"}, q, m_mem[int'(m_ptr[p]) % (1 << MAW)]);
        check({tag, " data read latency R6"}, 32'(lat), 32'd2);
        if (m_rs[p]) m_ptr[p] = m_ptr[p] + 14'd1;
    endtask

    initial begin
        #(20 * 100000);
        checks++; errors++;
        $display("FAIL watchdog expired actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] q; int lat;
        for (int p = 0; p < NP; p++) begin m_ptr[p] = '0; m_ws[p] = 0; m_rs[p] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state of every index
        for (int p = 0; p < NP; p++) idx_read(p, "R1");

        // R2: all-ones write keeps only the three fields
        idx_write(0, 32'hFFFF_FFFF, "R2");
        idx_read(0, "R2");
        idx_write(0, 32'h0100_0010, "R2");
        idx_read(0, "R2");

        // R3 R4: streamed writes with write stepping
        dat_write(0, 32'hA000_0001, "R3");
        dat_write(0, 32'hA000_0002, "R4");
        dat_write(0, 32'hA000_0003, "R4");
        dat_write(0, 32'hA000_0004, "R4");
        idx_read(0, "R4");

        // R5: streamed reads with read stepping on another pair
        idx_write(1, 32'h0200_0010, "R5");
        for (int k = 0; k < 4; k++) dat_read(1, "R5");
        idx_read(1, "R5");

        // R4 R5: no stepping when the switches are clear
        idx_write(2, 32'h0000_0014, "R4");
        dat_write(2, 32'h5555_AAAA, "R4");
        idx_read(2, "R4");
        dat_read(2, "R5");
        idx_read(2, "R5");

        // R8: pair 0 untouched by the others
        idx_read(0, "R8");

        // R7: wrap on write and on read
        idx_write(3, 32'h0100_FFFC, "R7");
        dat_write(3, 32'hDEAD_BEEF, "R7");
        idx_read(3, "R7");
        idx_write(3, 32'h0200_FFFC, "R7");
        dat_read(3, "R7");
        idx_read(3, "R7");

        // R3: only the low MEM_AW pointer bits select the word
        idx_write(0, 32'h0000_0414, "R3");
        dat_read(0, "R3");

        // R9: unmapped offsets
        access(1'b1, 8'h20, 32'h1234_5678, q, lat);
        check("R9 unmapped write latency", 32'(lat), 32'd1);
        access(1'b1, 8'h44, 32'h1234_5678, q, lat);
        access(1'b0, 8'h24, 32'h0, q, lat);
        check("R9 unmapped read value", q, 32'h0);
        check("R9 unmapped read latency", 32'(lat), 32'd1);
        for (int p = 0; p < NP; p++) idx_read(p, "R9");
        idx_write(1, 32'h0000_0010, "R9");
        for (int k = 0; k < 4; k++) begin
            dat_read(1, "R9");
            idx_write(1, 32'((k + 5) * 4), "R9");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule